// File: doc/BRIEF.md
# NAND Command and Address Front End

This block sits on the device side of an 8-bit multiplexed NAND bus. It watches the write strobe and, on every rising edge of it, sorts the byte on the I/O lines into a command, an address byte or a data byte according to the two latch-enable lines. It decodes the supported command set, gathers the address cycles each operation needs and keeps a sticky column pointer that picks the first half of the main area, the second half, or the spare area.

From that it issues single-cycle start requests to a behavioural back end: read, page program, double-page program, block erase, status, identification and reset. Each request carries the column and row it applies to. Program data bytes are passed on one at a time. The block drops commands that are not allowed while the back end is busy. It suppresses program and erase starts while write protect is asserted, and it reports undefined command codes on an error pulse.

Top module: `nand_cmd_frontend`

## Requirements
- R1: After reset no request, data or error pulse is issued, and the pointer reads as first half (area_o = 0).
- R2: A WE rising edge with CLE high is a command even if ALE is also high. With only ALE high the byte is an address. With both low the byte is data, and it is forwarded on data_valid_o/data_o only in the program data phase.
- R3: 00h or 01h followed by three address cycles issues a READ request (op 0) on the third cycle. The column is the first byte plus 256 when the pointer is in the second half. The row is {third byte bits 6:0, second byte}, so bit 7 of the third byte is ignored.
- R4: 50h with se_i low selects the spare area (area_o = 2) and a following read has column 512 + bits 3:0 of the first address byte. 50h with se_i high is ignored, and address bytes after it start nothing.
- R5: The pointer (area_o: 0 first half, 1 second half, 2 spare) persists into later program commands. A 10h that ends a program sequence moves a second-half pointer back to first half.
- R6: 80h (op 1) or 82h (op 2), three address cycles, at least one data byte and 10h issue a program request with the column and row of the address cycles. A 10h with no data byte loaded issues nothing.
- R7: 60h, two address cycles and D0h issue an ERASE request (op 3). Its row is {second byte bits 6:0, first byte} with the low five bits forced to zero.
- R8: While busy_i is high only FFh and 70h are acted on. Every other command, address byte and data byte has no effect.
- R9: Address bytes past the count an operation needs are ignored and are not taken as data.
- R10: After 80h/82h, any command other than 10h or FFh cancels the program. A later 10h then starts nothing until FFh is received.
- R11: With wp_ni low, 10h and D0h issue no request.
- R12: An undefined command code raises err_o for one cycle, issues no request and leaves a partly collected address sequence intact.
- R13: 70h issues STATUS (op 4). 90h plus one address cycle issues ID (op 5). FFh issues RESET (op 6) and returns to idle. Each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe; bytes latched on its rising edge |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| io_i | input | 8 | Multiplexed command/address/data byte |
| se_i | input | 1 | Spare enable; low allows the spare pointer |
| wp_ni | input | 1 | Write protect, active low |
| busy_i | input | 1 | Back end busy with program or erase |
| req_valid_o | output | 1 | One-cycle start request |
| req_op_o | output | 3 | Request opcode (0 read .. 6 reset) |
| req_col_o | output | 10 | Start column (0..527) |
| req_row_o | output | 15 | Page row address |
| data_valid_o | output | 1 | Program data byte strobe |
| data_o | output | 8 | Program data byte |
| err_o | output | 1 | Undefined command pulse |
| area_o | output | 2 | Current pointer area |

## Verification
The assertions assume that we_i, cle_i, ale_i, io_i and se_i are synchronous to clk_i and stay stable around each rising edge of the write strobe. They also assume that each strobe high or low phase lasts at least one clock, so two accepted bus cycles never fall on adjacent clocks. The bench holds the latch enables and the byte steady for two clocks before raising the strobe, keeps the strobe high for three clocks and low for two, and changes busy_i, wp_ni and se_i only between bus cycles.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_DATA} cyc_kind_e;
  typedef enum logic [1:0] {AREA_LO = 2'd0, AREA_HI = 2'd1, AREA_SPARE = 2'd2} area_e;
  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_PROG = 3'd1, OP_DPROG = 3'd2, OP_ERASE = 3'd3,
    OP_STATUS = 3'd4, OP_ID = 3'd5, OP_RESET = 3'd6
  } op_e;
  typedef enum logic [3:0] {
    C_RD_LO, C_RD_HI, C_RD_SP, C_PROG, C_DPROG, C_PCONF,
    C_ERASE, C_ECONF, C_RESET, C_STATUS, C_ID, C_BAD
  } cmd_e;
  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_ID_ADDR, S_PG_ADDR, S_PG_DATA, S_PG_CANCEL, S_ER_ADDR, S_ER_WAIT
  } st_e;
endpackage

// File: rtl/nand_fe_sample.sv
module nand_fe_sample
  import nand_fe_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            cle_i,
  input  logic            ale_i,
  input  logic [IO_W-1:0] io_i,
  output logic            strobe_o,
  output cyc_kind_e       kind_o,
  output logic [IO_W-1:0] byte_o
);
  logic we_q;
  logic rise;

  assign rise = we_i & ~we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q     <= 1'b1;   // no false edge if strobe is high at release
      strobe_o <= 1'b0;
      kind_o   <= CYC_DATA;
      byte_o   <= '0;
    end else begin
      we_q     <= we_i;
      strobe_o <= rise;
      if (rise) begin
        byte_o <= io_i;
        if (cle_i)      kind_o <= CYC_CMD;
        else if (ale_i) kind_o <= CYC_ADDR;
        else            kind_o <= CYC_DATA;
      end
    end
  end

  a_r2_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/nand_fe_decode.sv
module nand_fe_decode
  import nand_fe_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic [IO_W-1:0] byte_i,
  output cmd_e            cmd_o
);
  always_comb begin
    unique case (byte_i)
      8'h00:   cmd_o = C_RD_LO;
      8'h01:   cmd_o = C_RD_HI;
      8'h50:   cmd_o = C_RD_SP;
      8'h80:   cmd_o = C_PROG;
      8'h82:   cmd_o = C_DPROG;
      8'h10:   cmd_o = C_PCONF;
      8'h60:   cmd_o = C_ERASE;
      8'hD0:   cmd_o = C_ECONF;
      8'hFF:   cmd_o = C_RESET;
      8'h70:   cmd_o = C_STATUS;
      8'h90:   cmd_o = C_ID;
      default: cmd_o = C_BAD;
    endcase
  end
endmodule

// File: rtl/nand_fe_addr.sv
module nand_fe_addr #(
  parameter int IO_W    = 8,
  parameter int MAX_CYC = 3,
  localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         push_i,
  input  logic [IO_W-1:0]              byte_i,
  input  logic [CNT_W-1:0]             need_i,
  output logic                         last_o,
  output logic [MAX_CYC-1:0][IO_W-1:0] bytes_o
);
  logic [CNT_W-1:0]             cnt_q;
  logic [MAX_CYC-1:0][IO_W-1:0] addr_q;
  logic                         accept;

  assign accept = push_i && (cnt_q < need_i);
  assign last_o = accept && ((cnt_q + 1'b1) == need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (accept)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < MAX_CYC; g++) begin : g_slot
    logic hit;
    assign hit = accept && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  addr_q[g] <= '0;
      else if (hit) addr_q[g] <= byte_i;
    end
    // current byte visible in the cycle it arrives
    assign bytes_o[g] = hit ? byte_i : addr_q[g];
  end

  a_r9_drop_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clear_i && (cnt_q >= need_i) |=> $stable(cnt_q));
endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nand_fe_pkg::*;
#(
  parameter int IO_W       = 8,
  parameter int SPARE_BITS = 4,
  parameter int PG_BITS    = 5,
  localparam int COL_W     = IO_W + 2,
  localparam int ROW_W     = 2 * IO_W - 1,
  localparam int MAX_CYC   = 3,
  localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [IO_W-1:0]  io_i,
  input  logic             se_i,
  input  logic             wp_ni,
  input  logic             busy_i,
  output logic             req_valid_o,
  output logic [2:0]       req_op_o,
  output logic [COL_W-1:0] req_col_o,
  output logic [ROW_W-1:0] req_row_o,
  output logic             data_valid_o,
  output logic [IO_W-1:0]  data_o,
  output logic             err_o,
  output logic [1:0]       area_o
);
  localparam logic [CNT_W-1:0] RD_CYC  = CNT_W'(3);
  localparam logic [CNT_W-1:0] ER_CYC  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ID_CYC  = CNT_W'(1);
  localparam logic [ROW_W-1:0] ER_MASK = {{(ROW_W-PG_BITS){1'b1}}, {PG_BITS{1'b0}}};

  logic                         s_vld;
  cyc_kind_e                    s_kind;
  logic [IO_W-1:0]              s_byte;
  cmd_e                         cmd;
  st_e                          st_q;
  area_e                        area_q;
  logic                         dbl_q, have_data_q;
  logic [COL_W-1:0]             pg_col_q;
  logic [ROW_W-1:0]             pg_row_q, er_row_q;
  logic                         clear_c, push_c, last_c, cmd_c, cmd_live, in_pg;
  logic [CNT_W-1:0]             need_c;
  logic [MAX_CYC-1:0][IO_W-1:0] ab;
  logic [COL_W-1:0]             rd_col;
  logic [ROW_W-1:0]             rd_row, er_row;

  nand_fe_sample #(.IO_W(IO_W)) u_sample (
    .clk_i, .rst_ni, .we_i, .cle_i, .ale_i, .io_i,
    .strobe_o(s_vld), .kind_o(s_kind), .byte_o(s_byte));

  nand_fe_decode #(.IO_W(IO_W)) u_decode (.byte_i(s_byte), .cmd_o(cmd));

  nand_fe_addr #(.IO_W(IO_W), .MAX_CYC(MAX_CYC)) u_addr (
    .clk_i, .rst_ni, .clear_i(clear_c), .push_i(push_c), .byte_i(s_byte),
    .need_i(need_c), .last_o(last_c), .bytes_o(ab));

  assign cmd_c    = s_vld && (s_kind == CYC_CMD);
  assign cmd_live = cmd_c && (cmd != C_BAD) &&
                    (!busy_i || cmd == C_RESET || cmd == C_STATUS);
  assign in_pg    = (st_q == S_PG_ADDR) || (st_q == S_PG_DATA) || (st_q == S_PG_CANCEL);
  assign push_c   = s_vld && (s_kind == CYC_ADDR) && !busy_i;

  always_comb begin
    clear_c = 1'b0;
    if (cmd_live && !in_pg) begin
      unique case (cmd)
        C_RD_LO, C_RD_HI, C_PROG, C_DPROG, C_ERASE, C_ID, C_RESET: clear_c = 1'b1;
        C_RD_SP: clear_c = !se_i;
        default: clear_c = 1'b0;
      endcase
    end else if (cmd_live && cmd == C_RESET) begin
      clear_c = 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      S_RD_ADDR, S_PG_ADDR: need_c = RD_CYC;
      S_ER_ADDR:            need_c = ER_CYC;
      S_ID_ADDR:            need_c = ID_CYC;
      default:              need_c = '0;
    endcase
  end

  always_comb begin
    unique case (area_q)
      AREA_HI:    rd_col = {2'b01, ab[0]};
      AREA_SPARE: rd_col = {2'b10, {(IO_W-SPARE_BITS){1'b0}}, ab[0][SPARE_BITS-1:0]};
      default:    rd_col = {2'b00, ab[0]};
    endcase
  end
  assign rd_row = {ab[2][IO_W-2:0], ab[1]};
  assign er_row = {ab[1][IO_W-2:0], ab[0]} & ER_MASK;
  assign area_o = area_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; area_q <= AREA_LO; dbl_q <= 1'b0; have_data_q <= 1'b0;
      pg_col_q <= '0; pg_row_q <= '0; er_row_q <= '0;
      req_valid_o <= 1'b0; req_op_o <= '0; req_col_o <= '0; req_row_o <= '0;
      data_valid_o <= 1'b0; data_o <= '0; err_o <= 1'b0;
    end else begin
      req_valid_o  <= 1'b0;
      data_valid_o <= 1'b0;
      err_o        <= 1'b0;
      if (cmd_c && cmd == C_BAD) begin
        err_o <= 1'b1;
      end else if (cmd_live) begin
        if (cmd == C_RESET) begin
          req_valid_o <= 1'b1; req_op_o <= OP_RESET;
          req_col_o <= '0; req_row_o <= '0; st_q <= S_IDLE;
        end else if (st_q == S_PG_CANCEL) begin
          // waits for reset only
        end else if (in_pg) begin
          if (cmd == C_PCONF) begin
            st_q <= S_IDLE;
            if (area_q == AREA_HI) area_q <= AREA_LO;
            if (have_data_q && wp_ni) begin
              req_valid_o <= 1'b1; req_op_o <= dbl_q ? OP_DPROG : OP_PROG;
              req_col_o <= pg_col_q; req_row_o <= pg_row_q;
            end
          end else begin
            st_q <= S_PG_CANCEL;
          end
        end else begin
          unique case (cmd)
            C_RD_LO: begin area_q <= AREA_LO; st_q <= S_RD_ADDR; end
            C_RD_HI: begin area_q <= AREA_HI; st_q <= S_RD_ADDR; end
            C_RD_SP: if (!se_i) begin area_q <= AREA_SPARE; st_q <= S_RD_ADDR; end
            C_PROG, C_DPROG: begin
              st_q <= S_PG_ADDR; dbl_q <= (cmd == C_DPROG); have_data_q <= 1'b0;
            end
            C_ERASE: st_q <= S_ER_ADDR;
            C_ID:    st_q <= S_ID_ADDR;
            C_ECONF: if (st_q == S_ER_WAIT) begin
              st_q <= S_IDLE;
              if (wp_ni) begin
                req_valid_o <= 1'b1; req_op_o <= OP_ERASE;
                req_col_o <= '0; req_row_o <= er_row_q;
              end
            end
            C_STATUS: begin
              req_valid_o <= 1'b1; req_op_o <= OP_STATUS;
              req_col_o <= '0; req_row_o <= '0;
            end
            default: ;
          endcase
        end
      end else if (last_c) begin
        unique case (st_q)
          S_RD_ADDR: begin
            req_valid_o <= 1'b1; req_op_o <= OP_READ;
            req_col_o <= rd_col; req_row_o <= rd_row; st_q <= S_IDLE;
          end
          S_ID_ADDR: begin
            req_valid_o <= 1'b1; req_op_o <= OP_ID;
            req_col_o <= COL_W'(ab[0]); req_row_o <= '0; st_q <= S_IDLE;
          end
          S_PG_ADDR: begin pg_col_q <= rd_col; pg_row_q <= rd_row; st_q <= S_PG_DATA; end
          S_ER_ADDR: begin er_row_q <= er_row; st_q <= S_ER_WAIT; end
          default: ;
        endcase
      end else if (s_vld && s_kind == CYC_DATA && !busy_i && st_q == S_PG_DATA) begin
        data_valid_o <= 1'b1; data_o <= s_byte; have_data_q <= 1'b1;
      end
    end
  end

  a_r8_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_vld && busy_i && !(s_kind == CYC_CMD && (cmd == C_RESET || cmd == C_STATUS))
    |=> !req_valid_o && !data_valid_o);
  a_r11_wp_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_c && !wp_ni && (cmd == C_PCONF || cmd == C_ECONF) |=> !req_valid_o);
  a_r7_erase_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_op_o == OP_ERASE |-> req_row_o[PG_BITS-1:0] == '0);
  a_r4_spare_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_col_o[COL_W-1] |-> req_col_o[COL_W-2:SPARE_BITS] == '0);
  a_r12_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_valid_o);
  a_r13_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  a_r5_area_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_live && cmd == C_PCONF && (st_q == S_PG_ADDR || st_q == S_PG_DATA)
    |=> area_q != AREA_HI);
endmodule

// File: tb/nand_cmd_frontend_tb.sv
`timescale 1ns/1ps
module nand_cmd_frontend_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b1, cle = 1'b0, ale = 1'b0, se = 1'b1, wp_n = 1'b1, busy = 1'b0;
  logic [7:0] io = '0;
  logic req_valid, data_valid, err;
  logic [2:0] req_op;
  logic [9:0] req_col;
  logic [14:0] req_row;
  logic [7:0] data;
  logic [1:0] area;

  int n_chk = 0, n_bad = 0;
  int n_req = 0, n_err = 0, n_data = 0;
  int last_op = -1, last_col = -1, last_row = -1, last_data = -1;

  always #2.5 clk = ~clk;

  nand_cmd_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .cle_i(cle), .ale_i(ale), .io_i(io),
    .se_i(se), .wp_ni(wp_n), .busy_i(busy),
    .req_valid_o(req_valid), .req_op_o(req_op), .req_col_o(req_col), .req_row_o(req_row),
    .data_valid_o(data_valid), .data_o(data), .err_o(err), .area_o(area));

  always @(negedge clk) begin
    if (req_valid) begin
      n_req++; last_op = int'(req_op); last_col = int'(req_col); last_row = int'(req_row);
    end
    if (err) n_err++;
    if (data_valid) begin n_data++; last_data = int'(data); end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io = b; we = 1'b0;
    repeat (2) @(negedge clk);
    we = 1'b1;
    repeat (3) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] b); bus(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); bus(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b); bus(1'b0, 1'b0, b); endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 data_valid", int'(data_valid), 0);
    chk("R1 area", int'(area), 0);
    chk("R1 no pulses", n_req + n_err + n_data, 0);
  endtask

  task automatic t_read_lo;
    int r0 = n_req;
    cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'hF5);
    chk("R3 read count", n_req - r0, 1);
    chk("R3 read op", last_op, 0);
    chk("R3 read col", last_col, 'h012);
    chk("R3 read row", last_row, 'h7534);
  endtask

  task automatic t_read_hi_extra;
    int r0 = n_req;
    cmd(8'h01); adr(8'h80); adr(8'h01); adr(8'h02);
    chk("R3 hi col", last_col, 'h180);
    chk("R3 hi row", last_row, 'h0201);
    chk("R5 area hi", int'(area), 1);
    adr(8'h55);
    chk("R9 extra addr", n_req - r0, 1);
  endtask

  task automatic t_spare;
    se = 1'b0;
    cmd(8'h50); adr(8'hF7); adr(8'h03); adr(8'h00);
    chk("R4 spare col", last_col, 519);
    chk("R4 spare row", last_row, 'h0003);
    chk("R4 spare area", int'(area), 2);
    se = 1'b1;
  endtask

  task automatic t_spare_blocked;
    int r0, d0;
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h00);
    r0 = n_req; d0 = n_data;
    cmd(8'h50); adr(8'h01); adr(8'h02); adr(8'h03);
    chk("R4 se high ignored", n_req - r0, 0);
    chk("R4 area kept", int'(area), 0);
    cmd(8'h80); adr(8'h09); adr(8'h10); adr(8'h00); dat(8'hA5); cmd(8'h10);
    chk("R6 prog count", n_req - r0, 1);
    chk("R6 prog op", last_op, 1);
    chk("R5 prog col low", last_col, 9);
    chk("R6 prog row", last_row, 'h0010);
    chk("R2 data count", n_data - d0, 1);
    chk("R2 data byte", last_data, 'hA5);
  endtask

  task automatic t_prog_fallback;
    cmd(8'h01); cmd(8'h80); adr(8'h04); adr(8'h22); adr(8'h01);
    dat(8'h11); dat(8'h22); cmd(8'h10);
    chk("R5 hi prog col", last_col, 'h104);
    chk("R6 hi prog row", last_row, 'h0122);
    chk("R5 fallback area", int'(area), 0);
    cmd(8'h80); adr(8'h04); adr(8'h00); adr(8'h00); dat(8'h33); cmd(8'h10);
    chk("R5 fallback col", last_col, 'h004);
  endtask

  task automatic t_dprog;
    int r0 = n_req;
    cmd(8'h82); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'h10);
    chk("R6 no data no prog", n_req - r0, 0);
    cmd(8'h82); adr(8'h01); adr(8'h02); adr(8'h00); dat(8'h44); cmd(8'h10);
    chk("R6 dprog count", n_req - r0, 1);
    chk("R6 dprog op", last_op, 2);
    chk("R6 dprog row", last_row, 'h0002);
  endtask

  task automatic t_erase;
    int r0 = n_req;
    cmd(8'h60); adr(8'hFF); adr(8'hFF); cmd(8'hD0);
    chk("R7 erase count", n_req - r0, 1);
    chk("R7 erase op", last_op, 3);
    chk("R7 erase row", last_row, 'h7FE0);
  endtask

  task automatic t_wp;
    int r0 = n_req;
    wp_n = 1'b0;
    cmd(8'h60); adr(8'h20); adr(8'h00); cmd(8'hD0);
    chk("R11 erase blocked", n_req - r0, 0);
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); dat(8'h01); cmd(8'h10);
    chk("R11 prog blocked", n_req - r0, 0);
    wp_n = 1'b1;
  endtask

  task automatic t_busy;
    int r0 = n_req, d0 = n_data;
    busy = 1'b1;
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
    chk("R8 read dropped", n_req - r0, 0);
    dat(8'h77);
    chk("R8 data dropped", n_data - d0, 0);
    cmd(8'h70);
    chk("R13 status op", last_op, 4);
    chk("R8 status accepted", n_req - r0, 1);
    cmd(8'hFF);
    chk("R13 reset op", last_op, 6);
    busy = 1'b0;
  endtask

  task automatic t_cancel;
    int r0 = n_req;
    cmd(8'h80); adr(8'h05); adr(8'h00); adr(8'h00); dat(8'h55);
    cmd(8'h70); cmd(8'h10);
    chk("R10 cancelled", n_req - r0, 0);
    cmd(8'hFF);
    chk("R10 reset op", last_op, 6);
    cmd(8'h80); adr(8'h06); adr(8'h00); adr(8'h00); dat(8'h56); cmd(8'h10);
    chk("R10 after reset op", last_op, 1);
    chk("R10 after reset count", n_req - r0, 2);
  endtask

  task automatic t_undef;
    int r0 = n_req, e0 = n_err;
    cmd(8'h00); adr(8'h10); cmd(8'h33);
    chk("R12 err pulse", n_err - e0, 1);
    chk("R12 no req", n_req - r0, 0);
    adr(8'h20); adr(8'h30);
    chk("R12 state kept op", last_op, 0);
    chk("R12 state kept col", last_col, 'h010);
    chk("R12 state kept row", last_row, 'h3020);
  endtask

  task automatic t_id;
    int r0 = n_req;
    cmd(8'h90); adr(8'h00);
    chk("R13 id op", last_op, 5);
    chk("R13 id count", n_req - r0, 1);
  endtask

  task automatic t_prog_extra;
    int d0 = n_data;
    cmd(8'h80); adr(8'h08); adr(8'h01); adr(8'h00); adr(8'h77); dat(8'h66); cmd(8'h10);
    chk("R9 prog col", last_col, 8);
    chk("R9 prog row", last_row, 1);
    chk("R9 data count", n_data - d0, 1);
    chk("R9 data byte", last_data, 'h66);
  endtask

  task automatic t_cle_prio;
    int r0 = n_req;
    bus(1'b1, 1'b1, 8'h70);
    chk("R2 cle priority count", n_req - r0, 1);
    chk("R2 cle priority op", last_op, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=expired exp=done");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read_lo();
    t_read_hi_extra();
    t_spare();
    t_spare_blocked();
    t_prog_fallback();
    t_dprog();
    t_erase();
    t_wp();
    t_busy();
    t_cancel();
    t_undef();
    t_id();
    t_prog_extra();
    t_cle_prio();
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule